// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block turns a fast reference clock into the two timing signals of a serial audio link: a bit clock and a periodic frame sync. A divider counts reference cycles to form each bit period. A frame counter then counts bit periods to form the frame. The frame sync is held active for a programmed number of bit periods at the start of each frame. A one-cycle frame-start strobe marks the reference cycle in which a new frame begins, so that a neighbouring serializer can align its word boundaries.

All settings are plain input ports, and each count field carries its value minus one. A format selector sets the sync width in one of three ways:
- from an explicit width field;
- as half the frame, for two-channel formats with a word-select style sync;
- as a single bit period, for pulse-style formats.

Two polarity inputs invert the bit clock and the frame sync independently of each other. Settings are copied into a shadow register at reset and at each frame boundary. A change on the ports therefore never breaks a frame that is under way.

Top module: `afs_frame_sync_gen`

## Requirements
- R1: In the first cycle after synchronous reset, frame_start_o is 1, bclk_o is at its low-phase level (equal to cfg_bclk_inv) and fsync_o is at its active level (equal to cfg_fs_inv).
- R2: The bit period is D = cfg_div_m1+1 reference cycles. With cfg_bclk_inv=0, bclk_o is low for the first floor(D/2) cycles of each bit period and high for the rest. D must be at least 2 for bclk_o to toggle.
- R3: frame_start_o pulses for exactly one reference cycle, once every D*P reference cycles, where P = cfg_per_m1+1 bit periods.
- R4: With cfg_fmt=0, fsync_o is active for the first min(cfg_wid_m1+1, P) bit periods of the frame.
- R5: With cfg_fmt=1 (half frame), fsync_o is active for floor(P/2) bit periods, or for one bit period when P is 1.
- R6: With cfg_fmt=2 or cfg_fmt=3 (pulse), fsync_o is active for exactly one bit period, whatever cfg_wid_m1 holds.
- R7: With cfg_bclk_inv=0 and cfg_fs_inv=0, fsync_o is active low, and bclk_o falls on the reference cycle that starts a frame.
- R8: cfg_bclk_inv=1 inverts bclk_o, and cfg_fs_inv=1 makes fsync_o active high. The two controls act independently, so all four combinations are available.
- R9: Port changes made in the middle of a frame leave that frame's timing unchanged. They take effect from the next frame start.
- R10: frame_start_o is asserted on the reference cycle in which fsync_o first shows its active level for the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; also loads the settings |
| cfg_div_m1 | input | DIV_W | Bit period in reference cycles, minus one |
| cfg_per_m1 | input | FRM_W | Frame length in bit periods, minus one |
| cfg_wid_m1 | input | FRM_W | Sync width in bit periods, minus one (used when cfg_fmt=0) |
| cfg_fmt | input | 2 | Sync width source: 0 field, 1 half frame, 2 or 3 single bit |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fs_inv | input | 1 | Frame sync active high when set |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |

## Verification
Each setting is applied through a reset, and the bench then measures one whole frame: its length in reference cycles, the number of cycles in which the sync is active, and the number of cycles in which the bit clock is low.

The settings are chosen to tell the cases apart:
- Even and odd divider values separate the floor of the half bit period from a rounded value.
- Frames of odd length, including a one-bit frame, expose off-by-one errors in the half-frame width.
- A width field larger than the frame checks that the sync is held active for the whole frame.
- Format code 3 and a non-zero width field under the pulse formats show that the field is ignored.

The polarity inputs run through all four combinations. A directed test changes the ports part-way through a frame and checks that the old timing holds until the next frame start.

// File: rtl/afs_pkg.sv
`timescale 1ns/1ps
package afs_pkg;

    // Source of the frame-sync active width
    typedef enum logic [1:0] {
        FS_FMT_FIELD = 2'd0,   // explicit width field
        FS_FMT_HALF  = 2'd1,   // half the frame
        FS_FMT_PULSE = 2'd2,   // one bit period
        FS_FMT_PULSE2 = 2'd3   // one bit period (alias)
    } fs_fmt_e;

endpackage

// File: rtl/afs_bclk_div.sv
`timescale 1ns/1ps
module afs_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_m1,
    output logic [DIV_W-1:0] cnt,
    output logic             tick,
    output logic             phase_hi
);
    logic [DIV_W:0] span;

    assign span     = {1'b0, div_m1} + 1'b1;
    assign tick     = (cnt == div_m1);
    assign phase_hi = ({1'b0, cnt} >= (span >> 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= div_m1);  // R2
endmodule

// File: rtl/afs_frame_ctr.sv
`timescale 1ns/1ps
module afs_frame_ctr
    import afs_pkg::*;
#(
    parameter int FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [FRM_W-1:0] per_m1,
    input  logic [FRM_W-1:0] wid_m1,
    input  fs_fmt_e          fmt,
    output logic [FRM_W-1:0] cnt,
    output logic             wrap,
    output logic             active
);
    logic [FRM_W:0]   half_len;
    logic [FRM_W-1:0] eff_w;

    assign half_len = ({1'b0, per_m1} + 1'b1) >> 1;

    always_comb begin
        unique case (fmt)
            FS_FMT_FIELD: eff_w = wid_m1;
            FS_FMT_HALF:  eff_w = (per_m1 == '0) ? '0 : FRM_W'(half_len - 1'b1);
            default:      eff_w = '0;
        endcase
    end

    assign wrap   = tick && (cnt == per_m1);
    assign active = (cnt <= eff_w);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));  // R3
    AST_FRM_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= per_m1);  // R3
endmodule

// File: rtl/afs_frame_sync_gen.sv
`timescale 1ns/1ps
module afs_frame_sync_gen
    import afs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div_m1,
    input  logic [FRM_W-1:0] cfg_per_m1,
    input  logic [FRM_W-1:0] cfg_wid_m1,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_bclk_inv,
    input  logic             cfg_fs_inv,
    output logic             bclk_o,
    output logic             fsync_o,
    output logic             frame_start_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div_m1;
        logic [FRM_W-1:0] per_m1;
        logic [FRM_W-1:0] wid_m1;
        fs_fmt_e          fmt;
        logic             bclk_inv;
        logic             fs_inv;
    } cfg_t;

    cfg_t             live, shadow;
    logic [DIV_W-1:0] dcnt;
    logic [FRM_W-1:0] fcnt;
    logic             tick, phase_hi, wrap, active, boundary;

    assign live = '{div_m1: cfg_div_m1, per_m1: cfg_per_m1, wid_m1: cfg_wid_m1,
                    fmt: fs_fmt_e'(cfg_fmt), bclk_inv: cfg_bclk_inv, fs_inv: cfg_fs_inv};

    // settings change only where a frame ends
    assign boundary = wrap;

    always_ff @(posedge clk) begin
        if (rst || boundary) shadow <= live;
    end

    afs_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .div_m1   (shadow.div_m1),
        .cnt      (dcnt),
        .tick     (tick),
        .phase_hi (phase_hi)
    );

    afs_frame_ctr #(.FRM_W(FRM_W)) u_frm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .per_m1 (shadow.per_m1),
        .wid_m1 (shadow.wid_m1),
        .fmt    (shadow.fmt),
        .cnt    (fcnt),
        .wrap   (wrap),
        .active (active)
    );

    assign bclk_o        = phase_hi ^ shadow.bclk_inv;
    assign fsync_o       = ~active ^ shadow.fs_inv;
    assign frame_start_o = (dcnt == '0) && (fcnt == '0);

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(shadow));  // R9
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (fsync_o == shadow.fs_inv));  // R10
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        (frame_start_o && shadow.div_m1 != '0) |=> !frame_start_o);  // R3
    AST_BCLK_START: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (bclk_o == shadow.bclk_inv));  // R7
endmodule

// File: tb/afs_frame_sync_gen_test.sv
`timescale 1ns/1ps
module afs_frame_sync_gen_test;
    localparam int DIV_W = 8;
    localparam int FRM_W = 9;

    typedef struct packed {
        int div; int per; int wid; int fmt; int binv; int finv;
        int eper; int eact; int elow;
    } vec_t;

    // expected: eper = D*P, eact = active bits * D, elow = P*floor(D/2)
    localparam vec_t VEC [7] = '{
        '{1, 7, 2, 0, 0, 0, 16, 6, 8},       // R4 field width
        '{3, 15, 0, 1, 0, 0, 64, 32, 32},    // R5 half frame, even P
        '{2, 9, 5, 2, 1, 0, 30, 3, 10},      // R6 pulse, field ignored, bclk inverted
        '{4, 4, 0, 1, 0, 1, 25, 10, 10},     // R5 odd P, fs active high
        '{1, 0, 0, 1, 1, 1, 2, 2, 1},        // R5 one-bit frame
        '{7, 31, 40, 0, 0, 0, 256, 256, 128},// R4 width beyond frame
        '{1, 3, 7, 3, 0, 0, 8, 2, 4}         // R6 code 3
    };

    logic clk = 0, rst = 1;
    logic [DIV_W-1:0] cfg_div_m1 = '0;
    logic [FRM_W-1:0] cfg_per_m1 = '0, cfg_wid_m1 = '0;
    logic [1:0] cfg_fmt = '0;
    logic cfg_bclk_inv = 0, cfg_fs_inv = 0;
    logic bclk_o, fsync_o, frame_start_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    afs_frame_sync_gen #(.DIV_W(DIV_W), .FRM_W(FRM_W)) uut (
        .clk(clk), .rst(rst), .cfg_div_m1(cfg_div_m1), .cfg_per_m1(cfg_per_m1),
        .cfg_wid_m1(cfg_wid_m1), .cfg_fmt(cfg_fmt), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_fs_inv(cfg_fs_inv), .bclk_o(bclk_o), .fsync_o(fsync_o),
        .frame_start_o(frame_start_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_div_m1 = DIV_W'(v.div); cfg_per_m1 = FRM_W'(v.per);
        cfg_wid_m1 = FRM_W'(v.wid); cfg_fmt = 2'(v.fmt);
        cfg_bclk_inv = v.binv[0]; cfg_fs_inv = v.finv[0];
    endtask

    task automatic do_reset(input vec_t v);
        @(negedge clk);
        set_cfg(v);
        rst = 1;
        @(negedge clk);
        rst = 0;
    endtask

    // called at a negedge where frame_start_o is 1; returns at the next one
    task automatic run_frame(input int binv, input int finv, output int per,
                             output int act, output int low, output bit st_fs,
                             output bit st_bc, output bit one_cyc,
                             output bit prev_inact, output bit prev_hi);
        per = 0; act = 0; low = 0; one_cyc = 1;
        prev_inact = 0; prev_hi = 0;
        st_fs = (fsync_o == finv[0]);
        st_bc = (bclk_o == binv[0]);
        do begin
            if (fsync_o == finv[0]) act++;
            if (bclk_o == binv[0]) low++;
            prev_inact = (fsync_o != finv[0]);
            prev_hi = (bclk_o != binv[0]);
            per++;
            @(negedge clk);
            if (per == 1 && frame_start_o) one_cyc = 0;
        end while (!frame_start_o && per < 6000);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int per, act, low;
        bit st_fs, st_bc, one_cyc, prev_inact, prev_hi;
        for (int i = 0; i < 7; i++) begin
            do_reset(VEC[i]);
            // R1 state after reset
            chk(frame_start_o == 1'b1, "R1 start", int'(frame_start_o), 1);
            chk(bclk_o == VEC[i].binv[0], "R1 bclk", int'(bclk_o), VEC[i].binv);
            chk(fsync_o == VEC[i].finv[0], "R1 fsync", int'(fsync_o), VEC[i].finv);
            run_frame(VEC[i].binv, VEC[i].finv, per, act, low, st_fs, st_bc,
                      one_cyc, prev_inact, prev_hi);
            chk(per == VEC[i].eper, "R3 frame length", per, VEC[i].eper);
            chk(one_cyc, "R3 strobe width", int'(one_cyc), 1);
            chk(act == VEC[i].eact, "R4/R5/R6 sync width", act, VEC[i].eact);
            chk(low == VEC[i].elow, "R2 bclk low phase", low, VEC[i].elow);
            chk(st_fs, "R10 sync active at start", int'(st_fs), 1);
            chk(st_bc, "R7/R8 bclk low at start", int'(st_bc), 1);
            chk(prev_hi, "R7 bclk high before start", int'(prev_hi), 1);
            if (VEC[i].eact < VEC[i].eper)
                chk(prev_inact, "R8 sync inactive before start", int'(prev_inact), 1);
        end

        // R9: change mid-frame; current frame keeps 16 cycles, next is 12
        begin
            int n;
            vec_t nv;
            nv = '{2, 3, 0, 0, 0, 0, 12, 3, 4};
            do_reset(VEC[0]);
            n = 0;
            repeat (5) begin @(negedge clk); n++; end
            set_cfg(nv);
            do begin @(negedge clk); n++; end while (!frame_start_o && n < 6000);
            chk(n == 16, "R9 old frame kept", n, 16);
            run_frame(0, 0, per, act, low, st_fs, st_bc, one_cyc, prev_inact, prev_hi);
            chk(per == 12, "R9 new frame length", per, 12);
            chk(act == 3, "R9 new sync width", act, 3);
            chk(low == 4, "R9 new bclk low", low, 4);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule